// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block divides a CPU-rate clock enable into video scan lines and sequences the three horizontal timing pulses of a composite video frame: front porch, horizontal sync and back porch. Everything runs in one synchronous clock domain. A clock enable marks each CPU clock, so the block needs no derived clocks.

A position counter counts CPU clocks within the line. It is built from cascaded 4-bit digit stages. The carry out of the lowest stage is a one-in-sixteen tick. That tick is exported and it also advances the pulse sequencer. The counter restarts on its own after 208 CPU clocks. It restarts early when the CPU signals an interrupt acknowledge, which is I/O request and opcode fetch asserted together.

Each restart raises a front-porch flag and a line-start strobe for downstream line counting. Two tick-driven stages then turn the flag into one sync pulse followed by one back-porch pulse. Each pulse lasts one tick period, which is 16 CPU clocks.

Top module: `hline_timer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first enabled CPU clock, all outputs are 0 and the position counter is 0.
- R2: With no acknowledge, the position counter advances once per enabled CPU clock and restarts after exactly 208 enabled clocks. It returns to 0 from 207 and never reaches 208.
- R3: `line_start` goes high on the enabled clock that restarts the line. It stays high for exactly one CPU-clock period, until the next enabled clock.
- R4: An enabled clock with both `iorq_act` and `m1_act` high restarts the line at any position. Either input alone causes no restart.
- R5: `tick16` is high for one clock, together with `cpu_ce`, on every enabled clock where the position modulo 16 equals 15. The position is counted from the last restart.
- R6: `fporch` is high for the 16 CPU clocks that follow a restart, at positions 0 to 15.
- R7: `hsync` is high at positions 16 to 31 after a restart and changes only on a `tick16` clock.
- R8: `bporch` is high at positions 32 to 47 after a restart and changes only on a `tick16` clock.
- R9: While `cpu_ce` is low, the inputs `iorq_act` and `m1_act` have no effect on any output or on the counter.
- R10: When a restart and a tick fall on the same enabled clock, the front-porch flag is still set. The following sync and back-porch pulses keep their normal positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ce | input | 1 | One-clock enable marking each CPU clock |
| iorq_act | input | 1 | CPU I/O request active (high) |
| m1_act | input | 1 | CPU opcode-fetch cycle active (high) |
| tick16 | output | 1 | One-in-sixteen CPU-clock tick (carry of lowest digit) |
| line_start | output | 1 | High for one CPU clock after each line restart |
| fporch | output | 1 | Front-porch interval |
| hsync | output | 1 | Horizontal sync pulse |
| bporch | output | 1 | Back-porch interval |

## Verification
The line restart and the sixteen-clock tick can land on the same enabled clock. This happens on every natural wrap from position 207, and on an acknowledge given at any position ending in 15. In that case the flag set must win over the flag transfer.

The bench sweeps an acknowledge across every line position from 0 to 207. For each one it judges the strobe, the tick and the three pulses against positions computed arithmetically from the last restart. Sync and back-porch values are skipped only in the window where a restart interrupted a still-running earlier pulse. The bench also separately checks that a half acknowledge, or an acknowledge held while the enable is low, changes nothing.

// File: rtl/hline_pkg.sv
// Shared types for the horizontal line timing generator.
package hline_pkg;

    // Porch/sync sequencer state, one bit per pulse.
    typedef struct packed {
        logic fp;   // front-porch flag
        logic hs;   // first stage: horizontal sync
        logic bp;   // second stage: back porch
    } porch_t;

    localparam porch_t PORCH_IDLE = '{fp: 1'b0, hs: 1'b0, bp: 1'b0};

endpackage

// File: rtl/hl_digit_cnt.sv
// One digit stage of the cascaded line-position counter.
// Assumes: clr has priority over ce; carry is combinational and only
// asserted while ce is high and the digit is at its maximum value.
module hl_digit_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         clr,
    output logic [W-1:0] val,
    output logic         carry
);

    // Carry into the next digit on the enabled clock that wraps this digit.
    assign carry = ce && (&val);

    // Digit register: clear, count, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (ce)
            val <= val + 1'b1;
    end

endmodule

// File: rtl/hl_line_ctl.sv
// Line restart decision and the registered line-start strobe.
// Assumes: cnt is the full line position; acknowledge is sampled only
// on an enabled CPU clock.
module hl_line_ctl #(
    parameter int CNT_W    = 8,
    parameter int LINE_LEN = 208
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ce,
    input  logic             iorq_act,
    input  logic             m1_act,
    input  logic [CNT_W-1:0] cnt,
    output logic             restart,
    output logic             line_start
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(LINE_LEN - 1);

    logic at_end;
    logic int_ack;

    // End of line and interrupt acknowledge detection.
    assign at_end  = (cnt == LAST_POS);
    assign int_ack = iorq_act && m1_act;
    assign restart = cpu_ce && (at_end || int_ack);

    // Strobe held for one CPU-clock period after each restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_start <= 1'b0;
        else if (cpu_ce)
            line_start <= restart;
    end

endmodule

// File: rtl/hl_pulse_seq.sv
// Porch and sync sequencer: a one-shot flag moved through two stages.
// Assumes: restart and tick are single-clock pulses; a restart sets the
// flag even when a tick falls on the same clock.
module hl_pulse_seq
    import hline_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  logic   tick,
    output porch_t st
);

    // Front-porch flag: set by restart, dropped when handed to stage one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st.fp <= 1'b0;
        else if (restart)
            st.fp <= 1'b1;
        else if (tick && st.fp)
            st.fp <= 1'b0;
    end

    // Two-stage shift of the flag on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.hs <= 1'b0;
            st.bp <= 1'b0;
        end else if (tick) begin
            st.hs <= st.fp;
            st.bp <= st.hs;
        end
    end

endmodule

// File: rtl/hline_timer.sv
// Horizontal line timing generator: cascaded digit counter, restart
// control and porch/sync sequencer.
// Assumes: cpu_ce is a single-clock enable; all inputs synchronous to clk.
module hline_timer
    import hline_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int STAGES   = 2,
    parameter int LINE_LEN = 208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ce,
    input  logic iorq_act,
    input  logic m1_act,
    output logic tick16,
    output logic line_start,
    output logic fporch,
    output logic hsync,
    output logic bporch
);

    localparam int CNT_W = NIB_W * STAGES;

    logic [STAGES-1:0] st_ce;
    logic [STAGES-1:0] st_carry;
    logic [NIB_W-1:0]  st_val [STAGES];
    logic [CNT_W-1:0]  cnt_q;
    logic              restart;
    porch_t            pst;

    // Cascaded digit stages forming the line-position counter.
    for (genvar g = 0; g < STAGES; g++) begin : g_dig
        if (g == 0) begin : g_lo
            assign st_ce[g] = cpu_ce;
        end else begin : g_hi
            assign st_ce[g] = st_carry[g-1];
        end

        hl_digit_cnt #(.W(NIB_W)) u_dig (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (st_ce[g]),
            .clr   (restart),
            .val   (st_val[g]),
            .carry (st_carry[g])
        );

        assign cnt_q[g*NIB_W +: NIB_W] = st_val[g];
    end

    // Restart and strobe control.
    hl_line_ctl #(.CNT_W(CNT_W), .LINE_LEN(LINE_LEN)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ce     (cpu_ce),
        .iorq_act   (iorq_act),
        .m1_act     (m1_act),
        .cnt        (cnt_q),
        .restart    (restart),
        .line_start (line_start)
    );

    // Porch and sync sequencing on the low-digit carry.
    hl_pulse_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (st_carry[0]),
        .st      (pst)
    );

    // Output mapping.
    assign tick16 = st_carry[0];
    assign fporch = pst.fp;
    assign hsync  = pst.hs;
    assign bporch = pst.bp;

endmodule

// File: rtl/hline_timer_chk.sv
// Checker for the horizontal line timing generator, bound to the top.
module hline_timer_chk #(
    parameter int CNT_W    = 8,
    parameter int LINE_LEN = 208
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ce,
    input logic             iorq_act,
    input logic             m1_act,
    input logic             tick16,
    input logic             line_start,
    input logic             fporch,
    input logic             hsync,
    input logic             bporch,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(LINE_LEN - 1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LINE_LEN)); // R2

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && cnt == LAST_POS) |=> (cnt == '0 && line_start)); // R2

    AST_ACK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && iorq_act && m1_act) |=> (cnt == '0 && fporch && line_start)); // R4

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ce |=> $stable(line_start)); // R9

    AST_FP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fporch) |-> line_start); // R6

    AST_HS_FROM_FP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> $past(fporch)); // R7

    AST_BP_FROM_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bporch) |-> $past(hsync)); // R8

    AST_STAGES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> ($stable(hsync) && $stable(bporch))); // R7

endmodule

bind hline_timer hline_timer_chk #(.CNT_W(CNT_W), .LINE_LEN(LINE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ce     (cpu_ce),
    .iorq_act   (iorq_act),
    .m1_act     (m1_act),
    .tick16     (tick16),
    .line_start (line_start),
    .fporch     (fporch),
    .hsync      (hsync),
    .bporch     (bporch),
    .cnt        (cnt_q)
);

// File: tb/sim_hline_timer.sv
// Self-checking bench: acknowledge sweep over every line position.
module sim_hline_timer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_ce = 1'b0;
    logic iorq_act = 1'b0;
    logic m1_act = 1'b0;
    logic tick16, line_start, fporch, hsync, bporch;

    int total = 0;
    int bad = 0;
    int p = 0;          // expected position since last restart
    bit armed = 0;      // a restart has happened since reset
    bit clean = 1;      // earlier pulses were finished at the last restart
    bit ls_exp = 0;

    always #10 clk = ~clk;

    hline_timer u0 (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .iorq_act(iorq_act),
        .m1_act(m1_act), .tick16(tick16), .line_start(line_start),
        .fporch(fporch), .hsync(hsync), .bporch(bporch)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at pos %0d: actual=%b expected=%b", req, p, act, exp);
        end
    endtask

    // Check the registered outputs against the position model.
    task automatic chk_state(input string tag);
        chk({tag, " R6 fporch"}, fporch, armed && p < 16);
        if (p >= 16 || clean)
            chk({tag, " R7 hsync"}, hsync, armed && p >= 16 && p < 32);
        if (p >= 32 || clean)
            chk({tag, " R8 bporch"}, bporch, armed && p >= 32 && p < 48);
    endtask

    // One CPU clock: enable high across one rising edge.
    task automatic step(input logic iq, input logic mq);
        bit rs, at_tick;
        @(negedge clk);
        cpu_ce = 1'b1; iorq_act = iq; m1_act = mq;
        #1;
        at_tick = (p % 16 == 15);
        chk("R5 tick", tick16, at_tick);
        rs = (iq && mq) || (p == 207);
        if (rs) begin
            clean = !armed || (p >= 47);
            armed = 1;
            p = 0;
        end else begin
            p++;
        end
        ls_exp = rs;
        @(negedge clk);
        cpu_ce = 1'b0; iorq_act = 1'b0; m1_act = 1'b0;
        #1;
        chk("R5 tick idle", tick16, 1'b0);
        if (iq || mq) chk("R4 line_start", line_start, rs);
        else          chk("R3 line_start", line_start, rs);
        if (rs && at_tick) chk("R10 fporch", fporch, 1'b1);
        chk_state("");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 tick", tick16, 1'b0);
        chk("R1 line_start", line_start, 1'b0);
        chk("R1 fporch", fporch, 1'b0);
        chk("R1 hsync", hsync, 1'b0);
        chk("R1 bporch", bporch, 1'b0);
        rst_n = 1'b1;
        p = 0; armed = 0; clean = 1; ls_exp = 0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk); #1;
        chk("R1 fporch after release", fporch, 1'b0);
        chk("R1 line_start after release", line_start, 1'b0);

        // R2: free-running lines, count restarts.
        begin
            int starts = 0;
            for (int i = 0; i < 2 * 208 + 5; i++) begin
                step(1'b0, 1'b0);
                if (line_start) starts++;
            end
            chk("R2 two wraps", starts == 2, 1'b1);
        end

        // R4: half acknowledges must not restart.
        while (p != 100) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R4 no restart pos", p == 102, 1'b1);

        // R9: acknowledge held with enable low.
        while (p != 20) step(1'b0, 1'b0);
        @(negedge clk);
        iorq_act = 1'b1; m1_act = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk("R9 line_start", line_start, ls_exp);
        chk("R9 tick", tick16, 1'b0);
        chk_state("R9");
        iorq_act = 1'b0; m1_act = 1'b0;
        step(1'b0, 1'b0);
        chk("R9 pos kept", p == 21, 1'b1);

        // R4/R10: acknowledge at every line position.
        for (int c = 0; c < 208; c++) begin
            while (p != c) step(1'b0, 1'b0);
            step(1'b1, 1'b1);
            chk("R4 restart", p == 0, 1'b1);
        end
        for (int i = 0; i < 60; i++) step(1'b0, 1'b0);

        // R1: reset in mid-line.
        do_reset();
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule